// File: doc/BRIEF.md
# Glitch-Free Multi-Output Clock Gate

This block takes one reference clock and produces a bank of gated copies of it, one per lane (six by default). Each lane has its own enable pin and its own configuration enable bit. A lane runs only while both are high. The enable pin may change at any time relative to the clock. Each lane starts and stops cleanly at clock boundaries, so a stopped lane sits at logic low and no shortened or lengthened high pulse is ever produced. An active-low power-down input silences every lane at once. Analog drive properties are not modelled; each lane is a single-ended stand-in for a differential output.

The AND of pin and bit for every lane passes through a synchronizer clocked on the falling clock edge. It then drives a small per-lane state machine whose registered gate enable also changes only on falling edges. The lane output is the reference clock ANDed with that enable. The state machine has three states. `LANE_PARKED` is the output-low rest state. `LANE_WAKE` means a request has been seen once and must be confirmed on the next falling edge. `LANE_RUNNING` means the clock passes.

The transitions are as follows. Park-to-wake fires on a synchronized request. Wake-to-run fires when the request is still present on the next falling edge. Wake-to-park fires when the request has vanished. Run-to-park fires as soon as the synchronized request drops. Power-down does not go through the state machines. It uses a separate kill signal that is set immediately when the power-down input goes low and cleared through the synchronizer stages.

Top module: `clkgate_bank`

## Requirements
- R1: While `rst_n` is low, and after its release until a lane is enabled, every bit of `gck_o` stays 0.
- R2: Bit i of `lane_en_pin` and bit i of `lane_en_cfg` both control bit i of `gck_o`. A lane produces pulses only when both bits are 1, and a set pin with a clear config bit yields no pulse.
- R3: Take a cycle in which either enable of a running lane drops, just after a rising edge. The lane still delivers full pulses on the next two rising edges and none from the third one on.
- R4: A stopped lane holds its output at 0 for as long as it remains disabled.
- R5: Take a cycle in which the second enable of a lane rises, just after a rising edge. The lane's first pulse appears on rising edge SYNC_STAGES+2 after it. That is 4 with the defaults, inside a 2-to-6-cycle window, and no earlier edge carries a pulse.
- R6: When `pwr_dn_n` is driven low, every lane is 0 from the next rising edge on, whatever the enables say.
- R7: Suppose `pwr_dn_n` is released during the low half of the clock. Lanes whose enables stayed high resume on the third rising edge after the release, and the first two stay low.
- R8: A lane starts only if its synchronized request is present on two consecutive falling edges. A combined enable held for one clock cycle produces no pulse. One held for exactly two cycles produces exactly one pulse, on the fourth rising edge after it rose.
- R9: Every high pulse on any lane lasts exactly half a reference clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that every lane copies |
| rst_n | input | 1 | Asynchronous active-low reset of synchronizers and lane state |
| pwr_dn_n | input | 1 | Active-low power-down; low forces all lanes off |
| lane_en_pin | input | N_OUT | Asynchronous per-lane enable pins, active high |
| lane_en_cfg | input | N_OUT | Per-lane configuration enable bits, active high |
| gck_o | output | N_OUT | Gated clock outputs, one per lane, parked low when stopped |

## Verification
The bench builds the block with its default of six lanes and two synchronizer stages. That fixes the resume latency at four rising edges, the stop point at the third edge and the power-down recovery at the third edge, so each of these can be checked on an exact cycle. Six lanes let the stimulus mix odd and even lanes, so per-lane independence is exercised. With two stages, the one-cycle and two-cycle enable blips fall right at the edge of the wake confirmation, which exposes both of its sides.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Per-lane gating state
    typedef enum logic [1:0] {
        LANE_PARKED  = 2'd0,
        LANE_WAKE    = 2'd1,
        LANE_RUNNING = 2'd2
    } lane_state_t;

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk_i,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Falling-edge chain: every downstream change lands while the clock is low
    always_ff @(negedge clk_i or negedge arst_n) begin
        if (!arst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[LAST];

endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane
    import clkgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    input  logic kill_i,
    output logic gck_o
);

    lane_state_t st_q;
    lane_state_t st_d;
    logic        gate_en_q;

    // Next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LANE_PARKED:  if (req_i) st_d = LANE_WAKE;
            LANE_WAKE:    st_d = req_i ? LANE_RUNNING : LANE_PARKED;
            LANE_RUNNING: if (!req_i) st_d = LANE_PARKED;
            default:      st_d = LANE_PARKED;
        endcase
    end

    // State register, updated while the clock is low
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LANE_PARKED;
        end else begin
            st_q <= st_d;
        end
    end

    // Output register: gate enable also moves only on the falling edge
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            gate_en_q <= 1'b0;
        end else begin
            gate_en_q <= (st_d == LANE_RUNNING);
        end
    end

    assign gck_o = clk_i & gate_en_q & ~kill_i;

    // R5
    parked_never_opens_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
        (st_q == LANE_PARKED) |=> !gate_en_q);

    // R3
    drop_closes_gate_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
        ((st_q == LANE_RUNNING) && !req_i) |=> !gate_en_q);

    // R8
    open_via_wake_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
        $rose(gate_en_q) |-> ($past(st_q) == LANE_WAKE));

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank #(
    parameter int N_OUT       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             pwr_dn_n,
    input  logic [N_OUT-1:0] lane_en_pin,
    input  logic [N_OUT-1:0] lane_en_cfg,
    output logic [N_OUT-1:0] gck_o
);

    logic [N_OUT-1:0] req_raw;
    logic [N_OUT-1:0] req_sync;
    logic             kill;

    // Combine before synchronizing so a glitch of the AND is filtered too
    assign req_raw = lane_en_pin & lane_en_cfg;

    clkgate_sync #(
        .WIDTH  (N_OUT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_req_sync (
        .clk_i (ref_clk),
        .arst_n(rst_n),
        .d_i   (req_raw),
        .q_o   (req_sync)
    );

    // Kill: set at once by power-down, cleared through the stages on falling edges
    clkgate_sync #(
        .WIDTH  (1),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_kill_sync (
        .clk_i (ref_clk),
        .arst_n(pwr_dn_n),
        .d_i   (1'b0),
        .q_o   (kill)
    );

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            clkgate_lane u_lane (
                .clk_i (ref_clk),
                .rst_n (rst_n),
                .req_i (req_sync[i]),
                .kill_i(kill),
                .gck_o (gck_o[i])
            );
        end
    endgenerate

    // R6
    pwrdn_forces_low_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
        !pwr_dn_n |-> (gck_o == '0));

    // R1
    reset_quiet_chk: assert property (@(negedge ref_clk)
        !rst_n |-> (gck_o == '0));

endmodule

// File: tb/sim_clkgate_bank.sv
`timescale 1ns/1ps
module sim_clkgate_bank;

    localparam int NL = 6;

    typedef struct {
        int          cyc;
        logic [NL-1:0] exp;
        string       tag;
    } item_t;

    logic          ref_clk = 1'b0;
    logic          rst_n;
    logic          pwr_dn_n;
    logic [NL-1:0] pins;
    logic [NL-1:0] cfg;
    logic [NL-1:0] gck;

    int    n_chk  = 0;
    int    n_bad  = 0;
    int    cyc    = 0;
    bit    ended  = 0;
    item_t sb_q[$];

    clkgate_bank #(.N_OUT(NL), .SYNC_STAGES(2)) u0 (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .pwr_dn_n   (pwr_dn_n),
        .lane_en_pin(pins),
        .lane_en_cfg(cfg),
        .gck_o      (gck)
    );

    always #2.5 ref_clk = ~ref_clk;

    // Monitor: count rising edges, sample 1 ns into the high phase
    always @(posedge ref_clk) begin
        cyc = cyc + 1;
        #1.0;
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s stale item cyc=%0d now=%0d", it.tag, it.cyc, cyc);
            end else if (gck !== it.exp) begin
                n_bad++;
                $display("FAIL %s cyc=%0d actual=%b expected=%b", it.tag, cyc, gck, it.exp);
            end
        end
    end

    // Pulse width monitor, R9
    for (genvar g = 0; g < NL; g++) begin : g_pw
        realtime t_up = -1.0;
        always @(posedge gck[g]) t_up = $realtime;
        always @(negedge gck[g]) begin
            if (t_up >= 0.0) begin
                n_chk++;
                if (($realtime - t_up) < 2.49 || ($realtime - t_up) > 2.51) begin
                    n_bad++;
                    $display("FAIL R9 lane %0d width actual=%0t expected=2.5ns", g, $realtime - t_up);
                end
            end
            t_up = -1.0;
        end
    end

    task automatic expect_span(input int a, input int b, input logic [NL-1:0] e, input string tag);
        for (int k = a; k <= b; k++) begin
            item_t it;
            it.cyc = k;
            it.exp = e;
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    // Advance n rising edges, then land 1.5 ns into the high phase
    task automatic tick(input int n);
        repeat (n) @(posedge ref_clk);
        #1.5;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int c;
        rst_n    = 1'b0;
        pwr_dn_n = 1'b1;
        pins     = '0;
        cfg      = '0;

        // R1: quiet in reset
        tick(1);
        c = cyc;
        expect_span(c + 1, c + 3, 6'h00, "R1");
        tick(3);
        rst_n = 1'b1;

        // R2: pins alone are not enough
        c = cyc;
        pins = 6'h3F;
        expect_span(c + 1, c + 6, 6'h00, "R2");
        tick(6);

        // R5: config bits 0,2,4 -> first pulse exactly on edge c+4
        c = cyc;
        cfg = 6'h15;
        expect_span(c + 1, c + 3, 6'h00, "R5");
        expect_span(c + 4, c + 8, 6'h15, "R5");
        tick(8);

        // R3 / R4: drop pin 0
        c = cyc;
        pins = 6'h3E;
        expect_span(c + 1, c + 2, 6'h15, "R3");
        expect_span(c + 3, c + 8, 6'h14, "R4");
        tick(8);

        // R2 / R5: config for all lanes, lanes 1,3,5 join, lane 0 stays off (pin)
        c = cyc;
        cfg = 6'h3F;
        expect_span(c + 1, c + 3, 6'h14, "R5");
        expect_span(c + 4, c + 7, 6'h3E, "R2");
        tick(7);

        // R3: drop config bit 5
        c = cyc;
        cfg = 6'h1F;
        expect_span(c + 1, c + 2, 6'h3E, "R3");
        expect_span(c + 3, c + 6, 6'h1E, "R3");
        tick(6);

        // R6: power-down asserted in the low half
        c = cyc;
        #2.0;
        pwr_dn_n = 1'b0;
        expect_span(c + 1, c + 5, 6'h00, "R6");
        tick(5);

        // R7: release in the low half, resume on third edge
        c = cyc;
        #2.0;
        pwr_dn_n = 1'b1;
        expect_span(c + 1, c + 2, 6'h00, "R7");
        expect_span(c + 3, c + 6, 6'h1E, "R7");
        tick(6);

        // R8: one-cycle request on lane 0 gives no pulse
        c = cyc;
        expect_span(c + 1, c + 8, 6'h1E, "R8");
        pins = 6'h3F;
        tick(1);
        pins = 6'h3E;
        tick(7);

        // R8: two-cycle request on lane 0 gives exactly one pulse
        c = cyc;
        expect_span(c + 1, c + 3, 6'h1E, "R8");
        expect_span(c + 4, c + 4, 6'h1F, "R8");
        expect_span(c + 5, c + 9, 6'h1E, "R8");
        pins = 6'h3F;
        tick(2);
        pins = 6'h3E;
        tick(7);

        // R4: everything off, all lanes parked low
        c = cyc;
        cfg = 6'h00;
        expect_span(c + 1, c + 2, 6'h1E, "R3");
        expect_span(c + 3, c + 8, 6'h00, "R4");
        tick(9);

        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule